// File: doc/BRIEF.md
# End-of-Frame Payload Delay with Byte Count

This block sits between a frame header filter and the downstream container logic. Payload words are held in a two-entry delay buffer, so nothing leaves the block until two newer words are held behind it. When the end-of-frame delimiter arrives, the newest word in the buffer is known to be the received CRC. That word is taken out of the stream and compared with the value a separate CRC engine presents in the same cycle. The word before it is forwarded as the last word of the frame.

Each forwarded word carries a byte count. Interior words are always full. On the last word, the count is lowered by the number of fill bytes that the delimiter word announces. A CRC mismatch does not stop any data. It only sets the OK/not-OK status bit low. A discard request from the header filter empties the buffer.

Top module: `eof_payload_delay`

## Requirements
- R1: While and after reset, out_valid_o, out_last_o, crc_done_o and crc_ok_o are 0 until the block emits a word or completes a check.
- R2: A payload word pushed with in_valid_i=1 (and in_eof_i=0) is forwarded unchanged, in order, in the cycle after the push that makes it the third-newest word of the frame. The first two pushes of a frame produce no output.
- R3: Every forwarded word that is not the last word of its frame has out_bc_o=2'b11 (four bytes) and out_last_o=0.
- R4: The cycle after in_eof_i is asserted with two words held, the older held word is forwarded with out_last_o=1 and out_bc_o = 3 - fill. Fill is in_data_i[1:0] of the delimiter cycle. The byte-count code is 11 for four bytes, 10 for three, 01 for two and 00 for one.
- R5: The word held newest at end of frame (the CRC) is never forwarded. A frame of N pushes therefore yields N-1 forwarded words.
- R6: The cycle after in_eof_i with at least one word held, crc_done_o pulses for one cycle. crc_ok_o becomes 1 if the CRC word equals crc_calc_i sampled at the delimiter, and 0 otherwise, and it keeps that value until the next check.
- R7: A CRC mismatch does not suppress or alter any forwarded word, including the last one.
- R8: In the cycle after a cycle with neither in_valid_i nor in_eof_i, out_valid_o is 0.
- R9: discard_i empties the buffer, and it wins over in_valid_i and in_eof_i in the same cycle. No held word is ever emitted, no check completes, and the next frame starts with an empty buffer.
- R10: An end-of-frame with only one word held forwards nothing but still performs the CRC check on that word. An end-of-frame with an empty buffer does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Payload word present on in_data_i |
| in_eof_i | input | 1 | End-of-frame delimiter cycle; in_data_i holds the delimiter word |
| in_data_i | input | 32 | Payload word, or the delimiter word with fill count in bits 1:0 |
| discard_i | input | 1 | Drop the held words of the current frame |
| crc_calc_i | input | 32 | CRC computed by the engine, valid with in_eof_i |
| out_valid_o | output | 1 | Forwarded word valid |
| out_data_o | output | 32 | Forwarded payload word |
| out_bc_o | output | 2 | Valid bytes minus one in out_data_o |
| out_last_o | output | 1 | Last payload word of the frame |
| crc_done_o | output | 1 | One-cycle pulse: CRC check completed |
| crc_ok_o | output | 1 | Result of the last CRC check, 1 on match |

## Verification
A wrong buffer count or a slot that was not shifted shows at the ports within one frame. The output stream shifts by a word, the CRC word leaks out as payload, or a frame's last word goes missing, and this is seen on the cycle after the push or delimiter concerned. A wrong fill decode shows only on last words. Frames are therefore swept over all four fill values and several lengths, including lengths that leave one word or no word held. An input gap, a discard or a mismatched CRC must leave the stream's content untouched. The bench sees any corruption at the next forwarded word, and sees a missing status update on the crc_done_o pulse one cycle after the delimiter.

// File: rtl/epd_pkg.sv
package epd_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTES  = DATA_W / 8;
  localparam int unsigned BC_W   = $clog2(BYTES);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [BC_W-1:0]   bc_t;
  typedef logic [1:0]        fill_cnt_t;
endpackage

// File: rtl/epd_hold2.sv
module epd_hold2 #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              flush_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] head_o,
  output logic [DATA_W-1:0] tail_o,
  output logic [1:0]        cnt_o
);
  logic [DATA_W-1:0] slot0_q, slot1_q;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot0_q <= '0;
      slot1_q <= '0;
      cnt_q   <= 2'd0;
    end else if (clr_i || flush_i) begin
      cnt_q <= 2'd0;
    end else if (push_i) begin
      unique case (cnt_q)
        2'd0: begin
          slot0_q <= data_i;
          cnt_q   <= 2'd1;
        end
        2'd1: begin
          slot1_q <= data_i;
          cnt_q   <= 2'd2;
        end
        default: begin
          slot0_q <= slot1_q;
          slot1_q <= data_i;
        end
      endcase
    end
  end

  assign head_o = slot0_q;
  assign tail_o = slot1_q;
  assign cnt_o  = cnt_q;

  // R2: two entries at most
  a_r2_depth_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != 2'd3);
  // R9: clear empties the buffer
  a_r9_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == 2'd0);
endmodule

// File: rtl/epd_bc_enc.sv
module epd_bc_enc
  import epd_pkg::*;
(
  input  logic      last_i,
  input  fill_cnt_t fill_i,
  output bc_t       bc_o
);
  localparam bc_t FULL = bc_t'(BYTES - 1);

  // fill bytes trim the last word only
  always_comb begin
    if (last_i) bc_o = FULL - bc_t'(fill_i);
    else        bc_o = FULL;
  end
endmodule

// File: rtl/epd_crc_cmp.sv
module epd_crc_cmp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              check_i,
  input  logic [DATA_W-1:0] rx_crc_i,
  input  logic [DATA_W-1:0] calc_crc_i,
  output logic              done_o,
  output logic              ok_o
);
  logic done_q, ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= check_i;
      if (check_i) ok_q <= (rx_crc_i == calc_crc_i);
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;

  // R6: status holds between checks
  a_r6_ok_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !check_i |=> $stable(ok_q));
endmodule

// File: rtl/eof_payload_delay.sv
module eof_payload_delay
  import epd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_eof_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              discard_i,
  input  logic [DATA_W-1:0] crc_calc_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [BC_W-1:0]   out_bc_o,
  output logic              out_last_o,
  output logic              crc_done_o,
  output logic              crc_ok_o
);
  logic      push, flush, emit_mid, emit_fin, check;
  word_t     head, tail, rx_crc;
  logic [1:0] cnt;
  bc_t       bc_nxt;

  assign push  = in_valid_i && !in_eof_i && !discard_i;
  assign flush = in_eof_i && !discard_i;

  epd_hold2 #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .flush_i(flush),
    .clr_i  (discard_i),
    .data_i (in_data_i),
    .head_o (head),
    .tail_o (tail),
    .cnt_o  (cnt)
  );

  assign emit_mid = push && (cnt == 2'd2);
  assign emit_fin = flush && (cnt == 2'd2);
  assign check    = flush && (cnt != 2'd0);
  // newest held word is the CRC
  assign rx_crc   = (cnt == 2'd2) ? tail : head;

  epd_bc_enc u_bc (
    .last_i(emit_fin),
    .fill_i(in_data_i[1:0]),
    .bc_o  (bc_nxt)
  );

  epd_crc_cmp #(.DATA_W(DATA_W)) u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .check_i   (check),
    .rx_crc_i  (rx_crc),
    .calc_crc_i(crc_calc_i),
    .done_o    (crc_done_o),
    .ok_o      (crc_ok_o)
  );

  logic  vld_q, last_q;
  word_t data_q;
  bc_t   bc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      data_q <= '0;
      bc_q   <= '0;
    end else begin
      vld_q  <= emit_mid || emit_fin;
      last_q <= emit_fin;
      if (emit_mid || emit_fin) begin
        data_q <= head;
        bc_q   <= bc_nxt;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = data_q;
  assign out_bc_o    = bc_q;
  assign out_last_o  = last_q;

  a_r3_mid_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |-> out_bc_o == bc_t'(BYTES - 1));
  a_r4_last_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> (out_valid_o && $past(in_eof_i)
                    && out_bc_o == bc_t'(BYTES - 1) - bc_t'($past(in_data_i[1:0]))));
  a_r6_done_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_done_o |-> $past(in_eof_i) && !$past(discard_i));
  a_r8_gap_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !in_eof_i) |=> !out_valid_o);
  a_r9_discard_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_i |=> (!out_valid_o && !crc_done_o));
endmodule

// File: tb/eof_payload_delay_tb.sv
module eof_payload_delay_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, in_eof_i = 1'b0, discard_i = 1'b0;
  logic [31:0] in_data_i = '0, crc_calc_i = '0;
  logic        out_valid_o, out_last_o, crc_done_o, crc_ok_o;
  logic [31:0] out_data_o;
  logic [1:0]  out_bc_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  eof_payload_delay u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_eof_i(in_eof_i),
    .in_data_i(in_data_i), .discard_i(discard_i), .crc_calc_i(crc_calc_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_bc_o(out_bc_o),
    .out_last_o(out_last_o), .crc_done_o(crc_done_o), .crc_ok_o(crc_ok_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // apply one cycle of inputs, return after the edge has settled
  task automatic cyc(input bit v, input bit e, input bit d, input logic [31:0] dat,
                     input logic [31:0] crc);
    @(negedge clk_i);
    in_valid_i = v; in_eof_i = e; discard_i = d; in_data_i = dat; crc_calc_i = crc;
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [31:0] pay(input int f, input int i);
    return {8'(f), 8'h5A, 16'(i * 7 + 3)};
  endfunction

  function automatic logic [31:0] crcv(input int f);
    return 32'hC3C0_0000 ^ 32'(f * 911);
  endfunction

  // n payload words + CRC word; gaps inserted by pattern
  task automatic frame(input int f, input int n, input int fill, input bit good,
                       input bit gaps);
    int pushes;
    logic [31:0] w;
    pushes = n + 1;
    for (int i = 0; i < pushes; i++) begin
      if (gaps && ((f + i) % 3 == 0)) begin
        cyc(1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, '0);
        chk(out_valid_o == 1'b0, "R8 gap idle", out_valid_o, 0);
      end
      w = (i == n) ? (good ? crcv(f) : crcv(f) ^ 32'h1) : pay(f, i);
      cyc(1'b1, 1'b0, 1'b0, w, '0);
      if (i >= 2) begin
        chk(out_valid_o && out_data_o == pay(f, i - 2), "R2 delayed word",
            {31'b0, out_valid_o, out_data_o}, {32'd1, pay(f, i - 2)});
        chk(out_bc_o == 2'b11 && !out_last_o, "R3 full bc", {out_last_o, out_bc_o}, 3);
      end else begin
        chk(out_valid_o == 1'b0, "R2 fill-up silent", out_valid_o, 0);
      end
    end
    cyc(1'b0, 1'b1, 1'b0, {24'hE0F0_00, 6'b0, 2'(fill)}, crcv(f));
    if (n >= 1) begin
      chk(out_valid_o && out_last_o && out_data_o == pay(f, n - 1),
          good ? "R4 last word" : "R7 last word on bad crc",
          {out_valid_o, out_last_o, out_data_o}, {2'b11, pay(f, n - 1)});
      chk(out_bc_o == 2'(3 - fill), "R4 last bc", out_bc_o, 3 - fill);
    end else begin
      chk(out_valid_o == 1'b0, "R10 crc only, no data", out_valid_o, 0);
    end
    chk(crc_done_o == 1'b1 && crc_ok_o == good, "R6 crc status",
        {crc_done_o, crc_ok_o}, {1'b1, good});
    cyc(1'b0, 1'b0, 1'b0, '0, '0);
    chk(!out_valid_o && !crc_done_o, "R5 crc word not forwarded",
        {out_valid_o, crc_done_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f;
    bit prev_ok;
    repeat (3) @(posedge clk_i);
    #1;
    chk(!out_valid_o && !out_last_o && !crc_done_o && !crc_ok_o, "R1 reset",
        {out_valid_o, out_last_o, crc_done_o, crc_ok_o}, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, '0, '0);
    chk(!out_valid_o && !crc_ok_o, "R1 after reset", {out_valid_o, crc_ok_o}, 0);

    f = 1;
    for (int n = 0; n <= 6; n++)
      for (int fill = 0; fill < 4; fill++)
        for (int g = 0; g < 2; g++)
          for (int gp = 0; gp < 2; gp++) begin
            frame(f, n, fill, g[0], gp[0]);
            f++;
          end

    // R10: eof with empty buffer does nothing, status kept
    prev_ok = crc_ok_o;
    cyc(1'b0, 1'b1, 1'b0, 32'h3, 32'h1234);
    chk(!out_valid_o && !crc_done_o && crc_ok_o == prev_ok, "R10 empty eof",
        {out_valid_o, crc_done_o, crc_ok_o}, {2'b0, prev_ok});

    // R9: discard mid-frame, held words never appear
    cyc(1'b1, 1'b0, 1'b0, 32'hBAD0_0001, '0);
    cyc(1'b1, 1'b0, 1'b0, 32'hBAD0_0002, '0);
    cyc(1'b1, 1'b0, 1'b0, 32'hBAD0_0003, '0);
    chk(out_valid_o && out_data_o == 32'hBAD0_0001, "R2 pre-discard word",
        out_data_o, 32'hBAD0_0001);
    cyc(1'b1, 1'b0, 1'b1, 32'hBAD0_0004, '0);
    chk(!out_valid_o, "R9 discard wins over push", out_valid_o, 0);
    frame(900, 3, 1, 1'b1, 1'b0);

    // R9: discard together with eof
    cyc(1'b1, 1'b0, 1'b0, 32'h0000_0A01, '0);
    cyc(1'b1, 1'b0, 1'b0, 32'h0000_0A02, '0);
    cyc(1'b0, 1'b1, 1'b1, 32'h0, 32'h0000_0A02);
    chk(!out_valid_o && !crc_done_o, "R9 discard wins over eof",
        {out_valid_o, crc_done_o}, 0);
    frame(901, 2, 3, 1'b0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule